// File: doc/BRIEF.md
# Table-Driven Synchronous State Machine

This block is a clocked finite state machine whose transition and output behaviour sits in a small writable table, not in fixed gates. Every cycle the block looks up one table word. The address of that word is the present state followed by the registered external inputs. The word supplies the next state and the system outputs, and both are captured on the same clock edge. The machine can be redesigned by rewriting words through a load port, with no change to the logic.

A synchronous reset clears the state register and the input register. It also reloads the table with a built-in default program. That program is a four-state machine with two inputs and three outputs. A host or bench can overwrite any word after reset, one word per clock, before or during operation.

Top module: `tfsm_top`

## Requirements
- R1: While `rst` is high at a rising edge, the state register and the input register are cleared to 0, and `out_o` becomes 3'b111, which is the output value of state 00. These values are visible after that edge.
- R2: Each lookup uses the word at address {state_o, registered ev_in}, with the state in bits [3:2]. Bits [4:3] of that word become the next `state_o` and bits [2:0] become the next `out_o`, both at the same edge.
- R3: `ev_in` is captured in a register on every edge. The state change that an input value causes happens one edge after that capture, so a raw input change never alters `state_o` at the edge where it is first sampled.
- R4: With the default table, `out_o` depends only on `state_o`: 00 gives 111, 01 gives 011, 10 gives 101 and 11 gives 110.
- R5: With the default table, state 10 stays in 10 for registered inputs 00, 10 and 11.
- R6: With the default table, state 00 with inputs 00 goes to 11, state 01 with inputs 01 goes to 11, and state 01 with inputs 11 goes to 10.
- R7: When `wr_en` is high at an edge, `wr_data` is stored at `wr_addr` at that edge. A lookup of that address at the same edge still sees the old word, and a lookup at any later edge sees the new word.
- R8: Bits [7:5] of `wr_data` have no effect on `state_o` or `out_o`.
- R9: Reset restores the default words (hex, addresses 0 to 15: 1E 07 07 0B 0B 1E 07 15 15 0B 15 15 1E 15 1E 1E) and overwrites any word that was loaded earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all registers use the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 2 | External event inputs, registered before use |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 4 | Table word address for a write |
| wr_data | input | 8 | Table word to store; only bits [4:0] are kept |
| state_o | output | 2 | Present state register |
| out_o | output | 3 | Registered system outputs |

## Verification
The hardest case to reach from the ports is a write and a lookup of the same word at the same edge. Proving that the old word is used needs the state and the registered inputs to be sitting on exactly the address being written. The bench gets there by starting from reset, so the state is 00 and the registered inputs are 00. It then rewrites word 0 at the first edge and word 15 at the second edge, after it has used the two-edge input latency to steer the machine onto address 15. Later it walks the machine back to state 00 with inputs 00, to show that the rewritten word 0 takes effect, and then it resets to show that the default word returns.

// File: rtl/tfsm_pkg.sv
package tfsm_pkg;

    localparam int TF_STATE_W = 2;
    localparam int TF_IN_W    = 2;
    localparam int TF_OUT_W   = 3;
    localparam int TF_WORD_W  = 8;

    // Built-in program loaded by reset: bits [4:3] next state, [2:0] outputs
    function automatic logic [7:0] default_word(input int idx);
        logic [7:0] w;
        case (idx)
            0, 5, 12, 14, 15:  w = 8'h1E;
            1, 2, 6:           w = 8'h07;
            3, 4, 9:           w = 8'h0B;
            7, 8, 10, 11, 13:  w = 8'h15;
            default:           w = 8'h00;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/tfsm_table.sv
module tfsm_table #(
    parameter int ADDR_W = 4,
    parameter int WORD_W = 8,
    parameter int USED_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [USED_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [USED_W-1:0] mem_d [DEPTH];
    logic [USED_W-1:0] mem_q [DEPTH];
    logic              unused_hi;

    assign unused_hi = ^wr_data[WORD_W-1:USED_W];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_d[i] = USED_W'(tfsm_pkg::default_word(i));
            end
        end else if (wr_en) begin
            mem_d[wr_addr] = wr_data[USED_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_q[i] <= mem_d[i];
        end
    end

    assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/tfsm_core.sv
module tfsm_core #(
    parameter int STATE_W = 2,
    parameter int IN_W    = 2,
    parameter int OUT_W   = 3,
    parameter logic [OUT_W-1:0] RST_OUT = 3'b111
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [IN_W-1:0]          ev_in,
    input  logic [STATE_W+OUT_W-1:0] word,
    output logic [STATE_W+IN_W-1:0]  addr,
    output logic [IN_W-1:0]          in_q,
    output logic [STATE_W-1:0]       state_q,
    output logic [OUT_W-1:0]         out_q
);

    localparam int USED_W = STATE_W + OUT_W;

    typedef struct packed {
        logic [STATE_W-1:0] st;
        logic [IN_W-1:0]    inr;
        logic [OUT_W-1:0]   outv;
    } core_t;

    core_t cur_q, cur_d;

    always_comb begin
        cur_d = cur_q;
        if (rst) begin
            cur_d.st   = '0;
            cur_d.inr  = '0;
            cur_d.outv = RST_OUT;
        end else begin
            cur_d.inr  = ev_in;
            cur_d.st   = word[USED_W-1 -: STATE_W];
            cur_d.outv = word[OUT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= cur_d;
    end

    assign addr    = {cur_q.st, cur_q.inr};
    assign in_q    = cur_q.inr;
    assign state_q = cur_q.st;
    assign out_q   = cur_q.outv;

endmodule

// File: rtl/tfsm_top.sv
module tfsm_top #(
    parameter int STATE_W = tfsm_pkg::TF_STATE_W,
    parameter int IN_W    = tfsm_pkg::TF_IN_W,
    parameter int OUT_W   = tfsm_pkg::TF_OUT_W,
    parameter int WORD_W  = tfsm_pkg::TF_WORD_W,
    parameter logic [OUT_W-1:0] RST_OUT = 3'b111
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IN_W-1:0]           ev_in,
    input  logic                      wr_en,
    input  logic [STATE_W+IN_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [STATE_W-1:0]        state_o,
    output logic [OUT_W-1:0]          out_o
);

    localparam int ADDR_W = STATE_W + IN_W;
    localparam int USED_W = STATE_W + OUT_W;

    logic [ADDR_W-1:0] look_addr;
    logic [USED_W-1:0] look_word;
    logic [IN_W-1:0]   in_q;

    tfsm_table #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .USED_W (USED_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (look_addr),
        .rd_word (look_word)
    );

    tfsm_core #(
        .STATE_W (STATE_W),
        .IN_W    (IN_W),
        .OUT_W   (OUT_W),
        .RST_OUT (RST_OUT)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .ev_in   (ev_in),
        .word    (look_word),
        .addr    (look_addr),
        .in_q    (in_q),
        .state_q (state_o),
        .out_q   (out_o)
    );

endmodule

// File: rtl/tfsm_chk.sv
module tfsm_chk #(
    parameter int STATE_W = 2,
    parameter int IN_W    = 2,
    parameter int OUT_W   = 3
) (
    input logic                     clk,
    input logic                     rst,
    input logic [IN_W-1:0]          ev_in,
    input logic                     wr_en,
    input logic [IN_W-1:0]          in_q,
    input logic [STATE_W+OUT_W-1:0] look_word,
    input logic [STATE_W-1:0]       state_o,
    input logic [OUT_W-1:0]         out_o
);

    localparam int USED_W = STATE_W + OUT_W;

    logic clean_q;

    always_ff @(posedge clk) begin
        if (rst)        clean_q <= 1'b1;
        else if (wr_en) clean_q <= 1'b0;
    end

    function automatic logic [2:0] exp_out(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b111;
            2'b01:   return 3'b011;
            2'b10:   return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (state_o == '0 && in_q == '0 && out_o == 3'b111)); // R1

    AST_NEXT_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> state_o == $past(look_word[USED_W-1 -: STATE_W])); // R2

    AST_OUT_FROM_WORD: assert property (@(posedge clk) disable iff (rst)
        !rst |=> out_o == $past(look_word[OUT_W-1:0])); // R2

    AST_IN_REGISTERED: assert property (@(posedge clk) disable iff (rst)
        !rst |=> in_q == $past(ev_in)); // R3

    AST_OUT_BY_STATE: assert property (@(posedge clk) disable iff (rst)
        clean_q |-> out_o == exp_out(state_o)); // R4

    AST_HOLD_STATE_10: assert property (@(posedge clk) disable iff (rst)
        (clean_q && state_o == 2'b10 && in_q != 2'b01) |=> state_o == 2'b10); // R5

endmodule

bind tfsm_top tfsm_chk #(
    .STATE_W (STATE_W),
    .IN_W    (IN_W),
    .OUT_W   (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev_in     (ev_in),
    .wr_en     (wr_en),
    .in_q      (in_q),
    .look_word (look_word),
    .state_o   (state_o),
    .out_o     (out_o)
);

// File: tb/tfsm_top_tb.sv
`timescale 1ns/1ps
module tfsm_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ev_in = 2'b00;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] state_o;
    logic [2:0] out_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tfsm_top u_dut (
        .clk     (clk),
        .rst     (rst),
        .ev_in   (ev_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .state_o (state_o),
        .out_o   (out_o)
    );

    // each entry: {input driven before the edge, state expected after it}
    localparam int NVEC = 25;
    localparam logic [3:0] VEC [NVEC] = '{
        4'b11_11, 4'b01_11, 4'b00_10, 4'b01_10, 4'b10_01,
        4'b01_00, 4'b11_00, 4'b01_01, 4'b11_11, 4'b10_11,
        4'b01_11, 4'b00_10, 4'b10_10, 4'b11_10, 4'b01_10,
        4'b00_01, 4'b11_01, 4'b00_10, 4'b10_10, 4'b00_10,
        4'b01_10, 4'b10_01, 4'b00_00, 4'b10_11, 4'b00_11
    };

    function automatic logic [2:0] out_of(input logic [1:0] s);
        case (s)
            2'b00:   return 3'b111;
            2'b01:   return 3'b011;
            2'b10:   return 3'b101;
            default: return 3'b110;
        endcase
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        wr_en = 1'b0;
        ev_in = 2'b00;
        tick();
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_both(input logic [1:0] st, input logic [2:0] ov, input string tag);
        chk(8'(state_o), 8'(st), tag);
        chk(8'(out_o), 8'(ov), tag);
    endtask

    initial begin
        repeat (3) tick();
        do_reset();
        chk_both(2'b00, 3'b111, "R1 reset state");

        // vector walk through the default program (R2 R4 R5 R6)
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            ev_in = VEC[k][3:2];
            tick();
            chk_both(VEC[k][1:0], out_of(VEC[k][1:0]), "R2 R4 R5 R6 vector walk");
        end

        // raw input is not used at the edge that first samples it
        do_reset();
        @(negedge clk);
        ev_in = 2'b01;
        tick();
        chk_both(2'b11, 3'b110, "R3 registered input delay");
        tick();
        chk_both(2'b10, 3'b101, "R3 input applied one edge later");

        // same-edge write and lookup, then delayed effect
        do_reset();
        @(negedge clk);
        ev_in = 2'b11;
        wr_en = 1'b1;
        wr_addr = 4'd0;
        wr_data = 8'h08;
        tick();
        chk_both(2'b11, 3'b110, "R7 old word 0 at write edge");
        @(negedge clk);
        wr_addr = 4'd15;
        wr_data = 8'hEA;
        tick();
        chk_both(2'b11, 3'b110, "R7 old word 15 at write edge");
        @(negedge clk);
        wr_en = 1'b0;
        tick();
        chk_both(2'b01, 3'b010, "R7 R8 new word 15, upper bits ignored");
        @(negedge clk);
        ev_in = 2'b00;
        tick();
        chk_both(2'b10, 3'b101, "R7 untouched word 7");
        @(negedge clk);
        ev_in = 2'b01;
        tick();
        @(negedge clk);
        ev_in = 2'b10;
        tick();
        chk_both(2'b01, 3'b011, "R2 walk to state 01");
        @(negedge clk);
        ev_in = 2'b00;
        tick();
        chk_both(2'b00, 3'b111, "R2 walk to state 00");
        tick();
        chk_both(2'b01, 3'b000, "R7 rewritten word 0 used");

        // reset restores the default program
        do_reset();
        chk_both(2'b00, 3'b111, "R1 reset after rewrite");
        tick();
        chk_both(2'b11, 3'b110, "R9 default word 0 restored");

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        end
        #5;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule